// File: doc/BRIEF.md
# Asynchronous SRAM Page-Mode Controller

This block sits on a synchronous host clock and runs a 512K x 16 asynchronous static memory. The host hands it one request at a time over a valid/ready channel: a single-word write with a byte-lane mask, a single-word read, or a read burst of up to 16 words. A burst stays inside one 16-word page, so the upper 15 address bits stay fixed and only the low 4 bits advance. The controller drives both chip selects, the write strobe, the output enable, the byte-lane selects, the address and the direction of its own data drive. It counts clock cycles to honour the access time, the page access time, the write-pulse width and the cycle time. Each of these is a parameter in picoseconds and is rounded up to whole clocks.

Read words come back on a valid-only channel that has no back-pressure: each word is valid for exactly one cycle, and the consumer must take it in that cycle. On the request channel, a request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. A host that holds `req_valid` high while `req_ready` is low must keep every request field stable. `done` and `err` are plain one-cycle status pulses.

Between requests the memory is deselected so that it falls back to standby.

Top module: `sram_page_ctrl`

## Requirements
- R1: After reset, and in every cycle in which `req_ready` is high, the memory is deselected and idle: `ram_sel_n`=1, `ram_sel`=0, `ram_wr_n`=1, `ram_rd_n`=1, `ram_dq_oe`=0.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after an accepted valid request until that request has finished.
- R3: For a write, the edge that accepts it drives the address, the data (`ram_dq_oe`=1), the byte selects and `ram_wr_n`=0. `ram_bsel_n[1]` is the inverse of `req_be[1]` and covers data bits 15:8; `ram_bsel_n[0]` is the inverse of `req_be[0]` and covers bits 7:0. `ram_wr_n` stays low for max(ceil(T_WP/T_CLK), ceil(T_CYC/T_CLK)) cycles and then rises for one cycle, with data still driven. On the next edge `done` pulses, which is 10 cycles after acceptance with the default parameters.
- R4: The write strobe stays low for at least T_WP. Whenever `ram_wr_n` is low or `ram_dq_oe` is high, `ram_rd_n` is high.
- R5: A read samples the memory ceil(T_ACC/T_CLK) cycles after the accepting edge (9 cycles with the defaults). The result appears on `rd_data` with `rd_valid` high for one cycle.
- R6: `req_len` holds the burst word count minus one (0 to 15). A read returns words at `req_addr`, `req_addr`+1, and so on. Each word after the first comes ceil(T_PAGE/T_CLK) cycles (3 with the defaults) after the previous one. While the burst runs, the page bits `ram_addr[18:4]` and the chip selects stay unchanged.
- R7: A read with `req_addr[3:0]` + `req_len` > 15, or a write with `req_len` not equal to 0, is rejected. `err` pulses one cycle after acceptance, the memory is not touched, and no `rd_valid` or `done` follows.
- R8: On a read, a byte lane whose `req_be` bit is 0 reads back as zero in `rd_data`.
- R9: A read raises `done` in the same cycle as its last `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address; bits 3:0 are the word within the page |
| req_len | input | 4 | Burst word count minus one |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 1 = upper byte |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read word, unselected lanes zero |
| done | output | 1 | Request completed |
| err | output | 1 | Request rejected |
| ram_sel_n | output | 1 | Active-low chip select |
| ram_sel | output | 1 | Active-high chip select |
| ram_wr_n | output | 1 | Active-low write strobe |
| ram_rd_n | output | 1 | Active-low output enable |
| ram_bsel_n | output | 2 | Active-low byte-lane selects, bit 1 = upper |
| ram_addr | output | 19 | Memory word address |
| ram_dq_out | output | 16 | Data driven toward the memory |
| ram_dq_oe | output | 1 | Controller drives the data bus |
| ram_dq_in | input | 16 | Data returned by the memory |

## Verification
The bench builds the controller with its default parameters: a 10 ns clock, 85 ns access and cycle time, 30 ns page access and a 40 ns write pulse. These give 9-cycle first-word reads, 3-cycle page words and a 9-cycle write strobe, so a shortened first-word or page wait is caught on the exact cycle it happens. The memory model in the bench returns filler bytes until the address has been open for the access time, and until the word bits have been stable for the page time, counted up to the next sampling edge. Any early sample therefore shows up as wrong data. Because the write strobe is set by the cycle time rather than the pulse width, the write-duration formula is exercised on its longer branch.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_RECOVER} ctl_state_e;

  // whole clock cycles covering a duration, rounded up, never below one
  function automatic int unsigned cyc_ceil(int unsigned dur_ps, int unsigned clk_ps);
    int unsigned n;
    n = (dur_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction
endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_req_screen.sv
`timescale 1ns/1ps
module sram_req_screen #(
  parameter int WORD_W = 4
) (
  input  logic              is_write,
  input  logic [WORD_W-1:0] start_word,
  input  logic [WORD_W-1:0] len_m1,
  output logic              reject
);
  logic [WORD_W:0] end_word;

  assign end_word = {1'b0, start_word} + {1'b0, len_m1};
  // writes are single-word; reads must end inside the open page
  assign reject = is_write ? (len_m1 != '0) : end_word[WORD_W];
endmodule

// File: rtl/sram_word_stepper.sv
`timescale 1ns/1ps
module sram_word_stepper #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] start_word,
  input  logic [WORD_W-1:0] len_m1,
  input  logic              step,
  output logic [WORD_W-1:0] word,
  output logic              last
);
  logic [WORD_W-1:0] word_q, left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else if (load) begin
      word_q <= start_word;
      left_q <= len_m1;
    end else if (step) begin
      word_q <= word_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  assign word = word_q;
  assign last = (left_q == '0);
endmodule

// File: rtl/sram_page_ctrl.sv
`timescale 1ns/1ps
module sram_page_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int WORD_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 10000,
  parameter int T_ACC_PS  = 85000,
  parameter int T_PAGE_PS = 30000,
  parameter int T_CYC_PS  = 85000,
  parameter int T_WP_PS   = 40000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WORD_W-1:0]   req_len,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                done,
  output logic                err,
  output logic                ram_sel_n,
  output logic                ram_sel,
  output logic                ram_wr_n,
  output logic                ram_rd_n,
  output logic [DATA_W/8-1:0] ram_bsel_n,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [DATA_W-1:0]   ram_dq_out,
  output logic                ram_dq_oe,
  input  logic [DATA_W-1:0]   ram_dq_in
);
  localparam int BYTES  = DATA_W / 8;
  localparam int PAGE_W = ADDR_W - WORD_W;
  localparam int ACC_C  = int'(cyc_ceil(T_ACC_PS,  CLK_PS));
  localparam int PAGE_C = int'(cyc_ceil(T_PAGE_PS, CLK_PS));
  localparam int CYC_C  = int'(cyc_ceil(T_CYC_PS,  CLK_PS));
  localparam int WP_C   = int'(cyc_ceil(T_WP_PS,   CLK_PS));
  localparam int WE_C   = (WP_C > CYC_C) ? WP_C : CYC_C;
  localparam int MAX_C  = (ACC_C > WE_C) ? ACC_C : WE_C;
  localparam int TMR_W  = $clog2(MAX_C + 1);

  ctl_state_e        state_q;
  logic [PAGE_W-1:0] page_q;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] lane_mask;
  logic [TMR_W-1:0]  tmr_val;
  logic accept, reject, go, tmr_load, tmr_zero, last_word, step;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign go        = accept && !reject;
  assign step      = (state_q == ST_READ) && tmr_zero && !last_word;
  assign tmr_load  = go || step;
  assign tmr_val   = step      ? TMR_W'(PAGE_C - 1) :
                     req_write ? TMR_W'(WE_C - 1)   : TMR_W'(ACC_C - 1);
  assign ram_addr  = {page_q, word};

  generate
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign lane_mask[g*8 +: 8] = {8{~ram_bsel_n[g]}};
    end
  endgenerate

  sram_req_screen #(.WORD_W(WORD_W)) u_screen (
    .is_write  (req_write),
    .start_word(req_addr[WORD_W-1:0]),
    .len_m1    (req_len),
    .reject    (reject)
  );

  sram_wait_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_zero)
  );

  sram_word_stepper #(.WORD_W(WORD_W)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (go),
    .start_word(req_addr[WORD_W-1:0]),
    .len_m1    (req_len),
    .step      (step),
    .word      (word),
    .last      (last_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      page_q     <= '0;
      ram_sel_n  <= 1'b1;
      ram_sel    <= 1'b0;
      ram_wr_n   <= 1'b1;
      ram_rd_n   <= 1'b1;
      ram_bsel_n <= '1;
      ram_dq_out <= '0;
      ram_dq_oe  <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && reject) begin
            err <= 1'b1;
          end else if (go) begin
            page_q     <= req_addr[ADDR_W-1:WORD_W];
            ram_sel_n  <= 1'b0;
            ram_sel    <= 1'b1;
            ram_bsel_n <= ~req_be;
            if (req_write) begin
              ram_wr_n   <= 1'b0;
              ram_dq_out <= req_wdata;
              ram_dq_oe  <= 1'b1;
              state_q    <= ST_WRITE;
            end else begin
              ram_rd_n <= 1'b0;
              state_q  <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (tmr_zero) begin
            rd_valid <= 1'b1;
            rd_data  <= ram_dq_in & lane_mask;
            if (last_word) begin
              done       <= 1'b1;
              ram_sel_n  <= 1'b1;
              ram_sel    <= 1'b0;
              ram_rd_n   <= 1'b1;
              ram_bsel_n <= '1;
              state_q    <= ST_IDLE;
            end
          end
        end
        ST_WRITE: begin
          if (tmr_zero) begin
            ram_wr_n <= 1'b1;
            state_q  <= ST_RECOVER;
          end
        end
        default: begin
          done       <= 1'b1;
          ram_sel_n  <= 1'b1;
          ram_sel    <= 1'b0;
          ram_bsel_n <= '1;
          ram_dq_oe  <= 1'b0;
          state_q    <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sram_page_ctrl_chk.sv
`timescale 1ns/1ps
module sram_page_ctrl_chk #(
  parameter int ADDR_W  = 19,
  parameter int WORD_W  = 4,
  parameter int CLK_PS  = 10000,
  parameter int T_WP_PS = 40000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              done,
  input logic              err,
  input logic              ram_sel_n,
  input logic              ram_sel,
  input logic              ram_wr_n,
  input logic              ram_rd_n,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_dq_oe
);
  localparam int WP_LIM = (T_WP_PS + CLK_PS - 1) / CLK_PS;

  logic [7:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_cnt <= '0;
    else if (ram_wr_n)    low_cnt <= '0;
    else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 1'b1;
  end

  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_sel_n && !ram_sel && ram_wr_n && ram_rd_n && !ram_dq_oe));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (err || !req_ready));

  assert_no_read_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_wr_n || ram_dq_oe) |-> ram_rd_n);

  assert_write_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_wr_n) |-> (low_cnt >= 8'(WP_LIM)));

  assert_page_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_rd_n && $past(!ram_rd_n)) |->
      (ram_addr[ADDR_W-1:WORD_W] == $past(ram_addr[ADDR_W-1:WORD_W]) && $stable(ram_sel_n)));

  assert_reject_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !rd_valid));
endmodule

bind sram_page_ctrl sram_page_ctrl_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CLK_PS(CLK_PS), .T_WP_PS(T_WP_PS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .done(done), .err(err), .ram_sel_n(ram_sel_n),
  .ram_sel(ram_sel), .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n),
  .ram_addr(ram_addr), .ram_dq_oe(ram_dq_oe)
);

// File: tb/test_sram_page_ctrl.sv
`timescale 1ns/1ps
module test_sram_page_ctrl;
  localparam int ACC_N  = 9;   // ceil(85/10)
  localparam int PAGE_N = 3;   // ceil(30/10)
  localparam int WR_N   = 10;  // 9 strobe cycles + 1 recovery

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rd_valid, done, err;
  logic [15:0] rd_data, ram_dq_out;
  logic        ram_sel_n, ram_sel, ram_wr_n, ram_rd_n, ram_dq_oe;
  logic [1:0]  ram_bsel_n;
  logic [18:0] ram_addr;
  logic [15:0] ram_dq_in = '0;

  int checks = 0, fails = 0, cyc = 0;

  typedef struct { logic [15:0] d; int c; bit last; } exp_t;
  exp_t sb[$];
  logic [15:0] mem    [int];
  logic [15:0] shadow [int];

  sram_page_ctrl i_sram_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .err(err), .ram_sel_n(ram_sel_n), .ram_sel(ram_sel),
    .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n), .ram_bsel_n(ram_bsel_n),
    .ram_addr(ram_addr), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- asynchronous memory model ----------------
  realtime t_open = 0, t_word = 0, t_wfall = 0;
  logic [18:0] prev_addr = '0;
  logic [2:0]  prev_ctl = '0;
  always @(ram_addr or ram_sel_n or ram_sel or ram_rd_n) begin
    if (ram_addr[18:4] != prev_addr[18:4] || {ram_sel_n, ram_sel, ram_rd_n} != prev_ctl)
      t_open = $realtime;
    if (ram_addr[3:0] != prev_addr[3:0]) t_word = $realtime;
    prev_addr = ram_addr;
    prev_ctl  = {ram_sel_n, ram_sel, ram_rd_n};
  end

  always @(negedge clk) begin
    logic [15:0] w;
    bit on, ready;
    on    = !ram_sel_n && ram_sel && !ram_rd_n;
    ready = ($realtime + 5.0 - t_open >= 85.0) && ($realtime + 5.0 - t_word >= 30.0);
    w     = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 16'h0000;
    ram_dq_in[15:8] = (on && ready && !ram_bsel_n[1]) ? w[15:8] : 8'h5A;
    ram_dq_in[7:0]  = (on && ready && !ram_bsel_n[0]) ? w[7:0]  : 8'hC3;
  end

  always @(negedge ram_wr_n) t_wfall = $realtime;
  always @(posedge ram_wr_n) begin
    if (rst_n && !ram_sel_n && ram_sel) begin
      logic [15:0] w;
      chk(($realtime - t_wfall) >= 40.0, "R4", "write pulse ns",
          32'($rtoi($realtime - t_wfall)), 32'd40);
      chk(ram_rd_n == 1'b1 && ram_dq_oe == 1'b1, "R4", "oe high, bus driven at strobe end",
          {30'd0, ram_rd_n, ram_dq_oe}, 32'd3);
      w = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 16'h0000;
      if (!ram_bsel_n[1]) w[15:8] = ram_dq_out[15:8];
      if (!ram_bsel_n[0]) w[7:0]  = ram_dq_out[7:0];
      mem[int'(ram_addr)] = w;
    end
  end

  // ---------------- scoreboard monitor ----------------
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7", "unexpected rd_valid", 32'(rd_data), 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rd_data == e.d, "R5/R6/R8", "read data", 32'(rd_data), 32'(e.d));
        chk(cyc == e.c, "R5/R6", "read word cycle", 32'(cyc), 32'(e.c));
        chk(done == e.last, "R9", "done with last word", 32'(done), 32'(e.last));
      end
    end
  end

  // ---------------- driver ----------------
  task automatic offer(input bit wr, input logic [18:0] a, input logic [3:0] len,
                       input logic [15:0] d, input logic [1:0] be, output int ca);
    while (!req_ready) @(negedge clk);
    req_write = wr; req_addr = a; req_len = len; req_wdata = d; req_be = be;
    req_valid = 1'b1;
    @(negedge clk);
    ca = cyc;
    req_valid = 1'b0;
  endtask

  task automatic standby_chk(input string req);
    chk(ram_sel_n && !ram_sel && ram_rd_n && ram_wr_n && !ram_dq_oe, req, "standby after request",
        {27'd0, ram_sel_n, ram_sel, ram_rd_n, ram_wr_n, ram_dq_oe}, 32'b10110);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
    int ca;
    logic [15:0] s;
    offer(1'b1, a, 4'd0, d, be, ca);
    chk(!ram_wr_n && ram_dq_oe && ram_addr == a && ram_dq_out == d && ram_bsel_n == ~be,
        "R3", "write pins after accept", {ram_addr, 13'd0}, {a, 13'd0});
    chk(!req_ready, "R2", "busy after accept", 32'(req_ready), 32'd0);
    while (!done) @(negedge clk);
    chk(cyc == ca + WR_N, "R3", "write done cycle", 32'(cyc), 32'(ca + WR_N));
    s = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (be[1]) s[15:8] = d[15:8];
    if (be[0]) s[7:0]  = d[7:0];
    shadow[int'(a)] = s;
    @(negedge clk);
    standby_chk("R1");
  endtask

  task automatic do_read(input logic [18:0] a, input logic [3:0] len, input logic [1:0] be);
    int ca;
    logic [15:0] m;
    m = {{8{be[1]}}, {8{be[0]}}};
    offer(1'b0, a, len, 16'h0, be, ca);
    for (int k = 0; k <= int'(len); k++) begin
      exp_t e;
      logic [18:0] ak;
      ak = {a[18:4], a[3:0] + 4'(k)};
      e.d = (shadow.exists(int'(ak)) ? shadow[int'(ak)] : 16'h0000) & m;
      e.c = ca + ACC_N + k * PAGE_N;
      e.last = (k == int'(len));
      sb.push_back(e);
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    standby_chk("R1");
  endtask

  task automatic do_reject(input bit wr, input logic [18:0] a, input logic [3:0] len);
    int ca;
    offer(wr, a, len, 16'hFFFF, 2'b11, ca);
    chk(err && req_ready && ram_sel_n, "R7", "reject pulse, no access",
        {29'd0, err, req_ready, ram_sel_n}, 32'd7);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done || !ram_sel_n || err)
        chk(1'b0, "R7", "activity after reject", {30'd0, done, ram_sel_n}, 32'd1);
    end
  endtask

  initial begin
    #100000000;
    chk(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rd_valid && !done && !err, "R2", "ready after reset",
        {28'd0, req_ready, rd_valid, done, err}, 32'b1000);
    standby_chk("R1");

    // single word, full lanes, then partial lanes
    do_write(19'h00010, 16'h1234, 2'b11);
    do_read (19'h00010, 4'd0, 2'b11);                 // R5
    do_write(19'h00010, 16'hCDEF, 2'b10);             // R3 upper lane only
    do_read (19'h00010, 4'd0, 2'b11);                 // expect CD34
    do_read (19'h00010, 4'd0, 2'b01);                 // R8 expect 0034
    do_read (19'h00010, 4'd0, 2'b10);                 // R8 expect CD00

    // fill one page and burst through it
    for (int i = 0; i < 16; i++)
      do_write({15'h1234, 4'(i)}, 16'hA000 + 16'(i * 16'h0111), 2'b11);
    do_read({15'h1234, 4'd0},  4'd15, 2'b11);         // R6 full page
    do_read({15'h1234, 4'd3},  4'd11, 2'b11);         // R6 words 3..14
    do_read({15'h1234, 4'd15}, 4'd0,  2'b11);         // R6 boundary, last word
    do_read({15'h1234, 4'd4},  4'd3,  2'b01);         // R8 in a burst

    // rejected requests
    do_reject(1'b0, {15'h1234, 4'd5}, 4'd11);         // R7 crosses page
    do_reject(1'b0, {15'h1234, 4'd1}, 4'd15);         // R7 crosses by one
    do_reject(1'b1, 19'h00020, 4'd3);                 // R7 write burst
    do_read(19'h00010, 4'd0, 2'b11);                  // unchanged after rejects

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule